// File: doc/BRIEF.md
# Vectored Interrupt Controller with Shared Timer Line

This controller collects four external interrupt pins and one internal timer line, which three timers share. It turns them into a single request to the CPU. Software enables each pin on its own, and enables the timer line as a whole. It chooses level or edge detection for each pin, and it can silence everything with one global mask bit. Among the pending enabled sources, a fixed priority picks one. When the CPU acknowledges, the controller registers that source's vector address from a fixed table (0x30 plus four per source) and clears any edge-latched request belonging to it.

The three timers each raise a rollover pulse, and each pulse sets its own status bit. The shared timer line requests service while any status bit whose per-timer enable is set remains set. The interrupt service routine polls these bits to find which timer fired, then clears them by writing ones.

Top module: `vintc_top`

## Requirements
- R1: The registered vector for INT0..INT3 is 0x30, 0x34, 0x38, 0x3C, and for the timer line it is 0x40.
- R2: A pin whose enable bit (address 0, bits 3:0, bit i for INTi) is 0 never causes a request.
- R3: In level mode (address 1 bit i = 0), INTi is pending exactly while its pin is high. An acknowledge does not clear it.
- R4: In edge mode (address 1 bit i = 1), a rising edge latches INTi. The latch holds after the pin falls and is cleared by an acknowledge that grants INTi. A rising edge in the same cycle as that acknowledge leaves it latched.
- R5: While the global mask (address 2 bit 0) is 1, cpu_irq stays low. Latched requests survive the mask and appear once it is cleared.
- R6: Priority runs from INT0 (highest) through INT1, INT2 and INT3, with the timer line lowest.
- R7: A pulse on tmr_roll[i] sets status bit i (address 3, bits 2:0). Writing a 1 to a status bit clears it, writing a 0 leaves it unchanged, and an acknowledge leaves it unchanged. A set arriving in the same cycle as a clear wins.
- R8: The timer line requests when its line enable (address 0 bit 4) is 1 and some status bit i has its per-timer enable (address 2 bit 4+i) set.
- R9: After an edge where cpu_ack is high while cpu_irq is high, vec_valid is high for one cycle and vec_out holds the vector. cpu_irq is low in that cycle. An acknowledge with no request leaves vec_valid low and vec_out unchanged.
- R10: After reset, all registers read 0, cpu_irq and vec_valid are low, and vec_out is 0.
- R11: Register reads return the written value, limited to the defined bits: address 0 bits 4:0, address 1 bits 3:0, address 2 bits 6:4 and bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin | input | 4 | External interrupt pins INT0..INT3 |
| tmr_roll | input | 3 | One-cycle rollover pulses from the three timers |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| cpu_ack | input | 1 | Interrupt acknowledge from the CPU |
| vec_out | output | 8 | Vector address of the last granted source |
| vec_valid | output | 1 | One-cycle strobe marking a fresh vector |

## Verification
Two kinds of same-cycle collision get deliberate provocation. The first is an acknowledge that clears a pin's edge latch while a new rising edge arrives on that pin. The bench drives cpu_ack and the pin's rise in the same cycle, then expects the correct vector and a request that comes back once vec_valid drops. The second is a software write-one-to-clear and a timer rollover landing on the same status bit together. Reading the bit back afterwards must show it still set.

// File: rtl/vintc_pkg.sv
`timescale 1ns/1ps
package vintc_pkg;
    localparam int NPIN        = 4;
    localparam int NTMR        = 3;
    localparam int NSRC        = NPIN + 1;
    localparam int SIDX_W      = $clog2(NSRC);
    localparam int DW          = 8;
    localparam int AW          = 2;
    localparam int VEC_BASE    = 'h30;
    localparam int VEC_STEP    = 4;
    localparam int CTL_TEN_LSB = 4;

    typedef enum logic [AW-1:0] {
        RA_ENABLE = 2'd0,
        RA_MODE   = 2'd1,
        RA_CTRL   = 2'd2,
        RA_TSTAT  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic              hit;
        logic [SIDX_W-1:0] idx;
    } grant_t;

    function automatic logic [DW-1:0] vec_of(input logic [SIDX_W-1:0] idx);
        return DW'(VEC_BASE + VEC_STEP * int'(idx));
    endfunction
endpackage

// File: rtl/vintc_pin_trig.sv
`timescale 1ns/1ps
module vintc_pin_trig (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic edge_mode,
    input  logic clr,
    output logic pend
);
    logic prev_q;
    logic latch_q;
    logic rise;

    assign rise = pin & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            prev_q <= pin;
            if (!edge_mode)
                latch_q <= 1'b0;
            else if (rise)
                latch_q <= 1'b1;   // a fresh edge beats a same-cycle clear
            else if (clr)
                latch_q <= 1'b0;
        end
    end

    assign pend = edge_mode ? latch_q : pin;
endmodule

// File: rtl/vintc_tmr_stat.sv
`timescale 1ns/1ps
module vintc_tmr_stat #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] roll,
    input  logic [N-1:0] w1c,
    output logic [N-1:0] stat
);
    always_ff @(posedge clk) begin
        if (rst)
            stat <= '0;
        else
            stat <= (stat & ~w1c) | roll;
    end
endmodule

// File: rtl/vintc_arb.sv
`timescale 1ns/1ps
module vintc_arb #(
    parameter int N  = 5,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vintc_top.sv
`timescale 1ns/1ps
module vintc_top
    import vintc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] irq_pin,
    input  logic [NTMR-1:0] tmr_roll,
    input  logic            reg_we,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            cpu_irq,
    input  logic            cpu_ack,
    output logic [DW-1:0]   vec_out,
    output logic            vec_valid
);
    logic [NSRC-1:0] en_q;
    logic [NPIN-1:0] mode_q;
    logic            ctl_gmask;
    logic [NTMR-1:0] tmr_en_q;
    logic [NTMR-1:0] tmr_stat;
    logic [NTMR-1:0] tstat_w1c;
    logic [NPIN-1:0] pin_pend;
    logic [NPIN-1:0] ack_clr;
    logic [NSRC-1:0] src_req;
    logic            tmr_line;
    logic            ack_take;
    grant_t          grant;
    reg_addr_e       ra;
    logic            unused_wbits;

    assign ra           = reg_addr_e'(reg_addr);
    assign unused_wbits = ^reg_wdata;

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= '0;
            mode_q    <= '0;
            ctl_gmask <= 1'b0;
            tmr_en_q  <= '0;
        end else if (reg_we) begin
            case (ra)
                RA_ENABLE: en_q   <= reg_wdata[NSRC-1:0];
                RA_MODE:   mode_q <= reg_wdata[NPIN-1:0];
                RA_CTRL: begin
                    ctl_gmask <= reg_wdata[0];
                    tmr_en_q  <= reg_wdata[CTL_TEN_LSB +: NTMR];
                end
                default: ;
            endcase
        end
    end

    assign tstat_w1c = (reg_we && ra == RA_TSTAT) ? reg_wdata[NTMR-1:0] : '0;

    vintc_tmr_stat #(.N(NTMR)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .roll (tmr_roll),
        .w1c  (tstat_w1c),
        .stat (tmr_stat)
    );

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        assign ack_clr[g] = ack_take && (grant.idx == SIDX_W'(g));
        vintc_pin_trig u_trig (
            .clk       (clk),
            .rst       (rst),
            .pin       (irq_pin[g]),
            .edge_mode (mode_q[g]),
            .clr       (ack_clr[g]),
            .pend      (pin_pend[g])
        );
    end

    assign tmr_line = |(tmr_stat & tmr_en_q);
    assign src_req  = {tmr_line, pin_pend} & en_q & {NSRC{~ctl_gmask}};

    vintc_arb #(.N(NSRC)) u_arb (
        .req (src_req),
        .hit (grant.hit),
        .idx (grant.idx)
    );

    assign cpu_irq  = grant.hit & ~vec_valid;
    assign ack_take = cpu_ack & cpu_irq;

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_out   <= '0;
            vec_valid <= 1'b0;
        end else begin
            vec_valid <= ack_take;
            if (ack_take)
                vec_out <= vec_of(grant.idx);
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (ra)
            RA_ENABLE: reg_rdata[NSRC-1:0] = en_q;
            RA_MODE:   reg_rdata[NPIN-1:0] = mode_q;
            RA_CTRL: begin
                reg_rdata[0]                  = ctl_gmask;
                reg_rdata[CTL_TEN_LSB +: NTMR] = tmr_en_q;
            end
            RA_TSTAT:  reg_rdata[NTMR-1:0] = tmr_stat;
            default: ;
        endcase
    end
endmodule

// File: rtl/vintc_chk.sv
`timescale 1ns/1ps
module vintc_chk
    import vintc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            cpu_irq,
    input logic            cpu_ack,
    input logic            vec_valid,
    input logic [DW-1:0]   vec_out,
    input logic            gmask,
    input logic [NTMR-1:0] tmr_roll,
    input logic [NTMR-1:0] tstat
);
    a_r9_irq_low_with_vec: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> !cpu_irq);

    a_r9_ack_gives_vec: assert property (@(posedge clk) disable iff (rst)
        (cpu_ack && cpu_irq) |=> vec_valid);

    a_r9_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
        vec_valid |=> !vec_valid);

    a_r5_mask_silences: assert property (@(posedge clk) disable iff (rst)
        gmask |-> !cpu_irq);

    a_r1_vec_in_table: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (vec_out >= DW'(VEC_BASE) && vec_out <= vec_of(SIDX_W'(NSRC - 1))
                       && vec_out[1:0] == 2'b00));

    a_r7_roll_sets: assert property (@(posedge clk) disable iff (rst)
        (|tmr_roll) |=> ((tstat & $past(tmr_roll)) == $past(tmr_roll)));
endmodule

bind vintc_top vintc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_irq   (cpu_irq),
    .cpu_ack   (cpu_ack),
    .vec_valid (vec_valid),
    .vec_out   (vec_out),
    .gmask     (ctl_gmask),
    .tmr_roll  (tmr_roll),
    .tstat     (tmr_stat)
);

// File: tb/sim_vintc_top.sv
`timescale 1ns/1ps
module sim_vintc_top;
    import vintc_pkg::*;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NPIN-1:0] irq_pin = '0;
    logic [NTMR-1:0] tmr_roll = '0;
    logic            reg_we = 1'b0;
    logic [AW-1:0]   reg_addr = '0;
    logic [DW-1:0]   reg_wdata = '0;
    logic [DW-1:0]   reg_rdata;
    logic            cpu_irq;
    logic            cpu_ack = 1'b0;
    logic [DW-1:0]   vec_out;
    logic            vec_valid;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    vintc_top u0 (
        .clk(clk), .rst(rst), .irq_pin(irq_pin), .tmr_roll(tmr_roll),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cpu_irq(cpu_irq), .cpu_ack(cpu_ack),
        .vec_out(vec_out), .vec_valid(vec_valid)
    );

    // rows: {pin enables, pin levels, expected vector (0 = no request)}
    localparam int NROW = 9;
    localparam logic [23:0] VTAB [NROW] = '{
        24'h0F_0F_30, 24'h0E_0F_34, 24'h0C_0F_38, 24'h08_0F_3C,
        24'h0F_0A_34, 24'h0F_08_3C, 24'h05_0A_00, 24'h0F_00_00,
        24'h0F_0C_38
    };

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        tick;
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic do_ack;
        cpu_ack = 1'b1;
        tick;
        cpu_ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        repeat (3) tick;
        rst = 1'b0;
        tick;

        // R10 reset state
        check("R10 irq", cpu_irq, 0);
        check("R10 vec_valid", vec_valid, 0);
        check("R10 vec_out", vec_out, 0);
        for (int a = 0; a < 4; a++) begin
            rd(AW'(a), v);
            check("R10 reg", v, 0);
        end

        // R11 readback limited to defined bits
        wr(0, 8'hFF); rd(0, v); check("R11 enable", v, 8'h1F);
        wr(1, 8'hFF); rd(1, v); check("R11 mode", v, 8'h0F);
        wr(2, 8'hFF); rd(2, v); check("R11 ctrl", v, 8'h71);
        wr(2, 8'h00); wr(1, 8'h00); wr(0, 8'h00);

        // table walk: level mode, enables and priority (R1 R2 R3 R6 R9)
        for (int r = 0; r < NROW; r++) begin
            wr(0, VTAB[r][23:16]);
            irq_pin = VTAB[r][11:8];
            tick;
            check("R2 R6 irq", cpu_irq, VTAB[r][7:0] != 0);
            if (VTAB[r][7:0] != 0) begin
                do_ack;
                check("R9 vec_valid", vec_valid, 1);
                check("R1 R6 vector", vec_out, VTAB[r][7:0]);
                check("R9 irq blanked", cpu_irq, 0);
                tick;
                check("R9 valid drops", vec_valid, 0);
                check("R3 level stays", cpu_irq, 1);
            end
            irq_pin = '0;
            tick;
        end

        // R4 edge latch
        wr(1, 8'h0F); wr(0, 8'h0F);
        irq_pin = 4'b0100; tick;
        check("R4 edge latched", cpu_irq, 1);
        irq_pin = 4'b0000; tick;
        check("R4 holds after fall", cpu_irq, 1);
        do_ack;
        check("R4 vector", vec_out, 8'h38);
        tick;
        check("R4 ack clears", cpu_irq, 0);

        // R4 collision: new edge in the acknowledge cycle
        irq_pin = 4'b0010; tick;
        irq_pin = 4'b0000; tick;
        check("R4 second latch", cpu_irq, 1);
        cpu_ack = 1'b1; irq_pin = 4'b0010;
        tick;
        cpu_ack = 1'b0;
        check("R4 collision vector", vec_out, 8'h34);
        irq_pin = 4'b0000;
        tick;
        check("R4 collision keeps latch", cpu_irq, 1);
        do_ack; tick;
        check("R4 cleared after second ack", cpu_irq, 0);

        // R5 global mask, edge latch survives
        wr(2, 8'h01);
        irq_pin = 4'b1000; tick;
        check("R5 masked edge", cpu_irq, 0);
        irq_pin = 4'b0000; tick;
        check("R5 masked still", cpu_irq, 0);
        wr(2, 8'h00);
        check("R5 unmask shows latch", cpu_irq, 1);
        do_ack;
        check("R5 vector", vec_out, 8'h3C);
        tick;
        // R5 with a level pin
        wr(1, 8'h00);
        irq_pin = 4'b0001;
        wr(2, 8'h01);
        check("R5 masked level", cpu_irq, 0);
        wr(2, 8'h00);
        check("R5 unmasked level", cpu_irq, 1);
        irq_pin = 4'b0000; tick;
        check("R3 level fall", cpu_irq, 0);

        // R7 timer status
        tmr_roll = 3'b101; tick; tmr_roll = 3'b000;
        rd(3, v); check("R7 set", v, 8'h05);
        wr(3, 8'h00); rd(3, v); check("R7 zero write", v, 8'h05);
        wr(3, 8'h01); rd(3, v); check("R7 w1c", v, 8'h04);
        reg_addr = 3; reg_wdata = 8'h04; reg_we = 1'b1; tmr_roll = 3'b100;
        tick;
        reg_we = 1'b0; tmr_roll = 3'b000;
        rd(3, v); check("R7 set wins", v, 8'h04);

        // R8 timer line gating
        wr(0, 8'h10);
        check("R8 timer enable off", cpu_irq, 0);
        wr(2, 8'h40);
        check("R8 timer enable on", cpu_irq, 1);
        wr(0, 8'h00);
        check("R8 line enable off", cpu_irq, 0);
        wr(0, 8'h10);
        do_ack;
        check("R1 timer vector", vec_out, 8'h40);
        tick;
        rd(3, v); check("R7 ack keeps status", v, 8'h04);
        check("R8 still pending", cpu_irq, 1);

        // R6 timer loses to INT3
        wr(0, 8'h1F);
        irq_pin = 4'b1000; tick;
        do_ack;
        check("R6 INT3 over timer", vec_out, 8'h3C);
        tick;
        irq_pin = 4'b0000;
        wr(3, 8'h04);
        rd(3, v); check("R7 cleared", v, 8'h00);
        check("R8 no status no irq", cpu_irq, 0);

        // R9 acknowledge without a request
        do_ack;
        check("R9 no request valid", vec_valid, 0);
        check("R9 no request vector", vec_out, 8'h3C);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule